// File: doc/BRIEF.md
# Low-Side Switch Fault Filter and Retry Controller

This block sits between the command logic of a multi-channel low-side switch and its gate drivers. For each channel it takes the commanded on/off level and two raw comparator flags: a current-limit flag and an open-load flag. From these it produces the gate drive and single-cycle fault-set pulses. These pulses feed a separate fault register, which is not part of this block.

A short is qualified with two different filter windows. A current limit that is present from the moment the channel switches on must last the long turn-on sense window before it counts. A limit that appears once the channel is running normally needs only the short fault-sense window. A confirmed short switches the channel off. The channel then alternates between a refresh (off) period and a sense (on) period for as long as the short persists and the command stays on. If the limit does not reappear in a sense period, the channel returns to normal operation.

Open load is qualified while the gate is off. Counted from turn-off, the flag must persist for the open-load sense time. On a channel that has already been off for that long, a much shorter delay applies. A per-channel enable extends open-load checking to the on state. A global shutdown input forces every gate off in the same cycle, whatever the commands are. All times are counted in clock cycles and are set by parameters.

Top module: `lss_fault_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after its release, every gate_o, short_set_o and open_set_o bit is 0.
- R2: If ilim_i is high from the first on-cycle for T_SS consecutive cycles, the gate turns off and short_set_o pulses high in the following cycle (T_SS+1 cycles after the command rose).
- R3: A current limit at turn-on that ends before T_SS cycles causes no short pulse, and the gate stays on.
- R4: In normal on operation, a current limit is confirmed after T_FS consecutive cycles, with the gate off and short_set_o high in the next cycle. A shorter burst has no effect.
- R5: After a confirmed short, the gate stays off for T_REF cycles and then on for up to T_SS cycles. This repeats while ilim_i stays high, and the retries raise no further short_set_o pulse.
- R6: If ilim_i is low during a retry on-period, the channel stays on in normal operation.
- R7: When cmd_i falls, the gate is off in the next cycle and any retry sequence is abandoned. A new command switches the gate on one cycle later, without waiting for the refresh time.
- R8: While kill_i is high, every gate_o is 0 in the same cycle and commands are ignored. After release, a commanded gate comes back on one cycle later.
- R9: If dlow_i is high from the first off-cycle after turn-off, open_set_o pulses in the cycle after T_OL flagged off-cycles.
- R10: On a channel that has been off for at least T_OL cycles, dlow_i held high for T_OLF cycles gives an open_set_o pulse in the next cycle.
- R11: While the gate is on, dlow_i is ignored unless ol_on_en_i is set for that channel. When it is set, T_OL consecutive flagged cycles give a pulse.
- R12: Each fault-set pulse lasts one cycle. A flag that stays high does not raise a second open_set_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_i | input | N_CH | Commanded channel on level |
| ol_on_en_i | input | N_CH | Enables open-load checking while the channel is on |
| ilim_i | input | N_CH | Raw current-limit / short comparator flag |
| dlow_i | input | N_CH | Raw open-load (drain below threshold) comparator flag |
| kill_i | input | 1 | Global short shutdown, forces all gates off |
| gate_o | output | N_CH | Gate drive per channel |
| short_set_o | output | N_CH | One-cycle pulse on a confirmed short |
| open_set_o | output | N_CH | One-cycle pulse on a confirmed open load |

## Verification
Current limit is applied in three patterns. The first holds it from turn-on and the second drops it just before the turn-on window ends; together they separate the long window from a plain threshold. The third raises it mid-on-time, once as a short burst and once held, which proves that the short window applies only after the channel has settled. A persistent short is followed through a full refresh/sense period and then released during a sense period, which shows both that retries raise no new pulse and that normal operation resumes. Open load is checked on three paths: just after turn-off, after a long off time, and while on with the enable clear and set. These tell the long delay, the fast delay and the on-state gating apart.

// File: rtl/lss_pkg.sv
package lss_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_ON_INIT,
    ST_ON_RUN,
    ST_RETRY_OFF,
    ST_RETRY_ON
  } sw_state_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/lss_short_fsm.sv
module lss_short_fsm
  import lss_pkg::*;
#(
  parameter int T_SS  = 16,
  parameter int T_FS  = 4,
  parameter int T_REF = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_i,
  input  logic kill_i,
  input  logic ilim_i,
  output logic gate_o,
  output logic short_set_o
);
  localparam int TMAX = max3(T_SS, T_FS, T_REF);
  localparam int CW   = $clog2(TMAX + 1);

  sw_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic en, confirm, on_st;

  assign en = cmd_i & ~kill_i;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    confirm = 1'b0;
    unique case (st_q)
      ST_OFF: if (en) begin
        st_d  = ST_ON_INIT;
        cnt_d = '0;
      end
      ST_ON_INIT, ST_RETRY_ON: begin
        if (!en) st_d = ST_OFF;
        else if (!ilim_i) begin
          st_d  = ST_ON_RUN;
          cnt_d = '0;
        end else if (cnt_q == CW'(T_SS - 1)) begin
          st_d    = ST_RETRY_OFF;
          cnt_d   = '0;
          confirm = (st_q == ST_ON_INIT); // retries never re-report
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_ON_RUN: begin
        if (!en) st_d = ST_OFF;
        else if (!ilim_i) cnt_d = '0;
        else if (cnt_q == CW'(T_FS - 1)) begin
          st_d    = ST_RETRY_OFF;
          cnt_d   = '0;
          confirm = 1'b1;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_RETRY_OFF: begin
        if (!en) st_d = ST_OFF;
        else if (cnt_q == CW'(T_REF - 1)) begin
          st_d  = ST_RETRY_ON;
          cnt_d = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      default: st_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_OFF;
      cnt_q       <= '0;
      short_set_o <= 1'b0;
    end else begin
      st_q        <= st_d;
      cnt_q       <= cnt_d;
      short_set_o <= confirm;
    end
  end

  assign on_st  = (st_q == ST_ON_INIT) || (st_q == ST_ON_RUN) || (st_q == ST_RETRY_ON);
  assign gate_o = on_st & ~kill_i;

  a_r8_kill_forces_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |=> st_q == ST_OFF);
  a_r7_cmd_low_to_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_i |=> st_q == ST_OFF);
  a_r2_set_with_gate_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_set_o |-> !gate_o);
  a_r12_short_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_set_o |=> !short_set_o);
  a_r5_retry_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_RETRY_ON |=> !short_set_o);
endmodule

// File: rtl/lss_open_det.sv
module lss_open_det #(
  parameter int T_OL  = 12,
  parameter int T_OLF = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  input  logic on_chk_i,
  input  logic dlow_i,
  output logic open_set_o
);
  localparam int CW = $clog2(T_OL + 1);

  logic [CW-1:0] off_cnt_q, dl_cnt_q;
  logic [CW:0]   dl_sum, lim;
  logic active, settled, hit, done_q;

  assign active  = ~gate_i | on_chk_i;
  assign settled = ~gate_i && (off_cnt_q == CW'(T_OL));
  assign lim     = settled ? (CW+1)'(T_OLF) : (CW+1)'(T_OL);
  assign dl_sum  = {1'b0, dl_cnt_q} + 1'b1;
  assign hit     = active & dlow_i & (dl_sum >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_cnt_q  <= '0;
      dl_cnt_q   <= '0;
      done_q     <= 1'b0;
      open_set_o <= 1'b0;
    end else begin
      if (gate_i) off_cnt_q <= '0;
      else if (off_cnt_q != CW'(T_OL)) off_cnt_q <= off_cnt_q + 1'b1;
      if (!(active && dlow_i)) dl_cnt_q <= '0;
      else if (dl_cnt_q != CW'(T_OL)) dl_cnt_q <= dl_cnt_q + 1'b1;
      done_q     <= active & dlow_i & (done_q | hit);
      open_set_o <= hit & ~done_q;
    end
  end

  a_r12_open_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_set_o |=> !open_set_o);
  a_r11_on_check_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_i && !on_chk_i) |=> !open_set_o);
  a_r9_open_needs_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_set_o |-> $past(dlow_i));
endmodule

// File: rtl/lss_fault_ctrl.sv
module lss_fault_ctrl #(
  parameter int N_CH  = 4,
  parameter int T_SS  = 16,
  parameter int T_FS  = 4,
  parameter int T_REF = 40,
  parameter int T_OL  = 12,
  parameter int T_OLF = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] cmd_i,
  input  logic [N_CH-1:0] ol_on_en_i,
  input  logic [N_CH-1:0] ilim_i,
  input  logic [N_CH-1:0] dlow_i,
  input  logic            kill_i,
  output logic [N_CH-1:0] gate_o,
  output logic [N_CH-1:0] short_set_o,
  output logic [N_CH-1:0] open_set_o
);
  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    lss_short_fsm #(.T_SS(T_SS), .T_FS(T_FS), .T_REF(T_REF)) u_short (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cmd_i      (cmd_i[ch]),
      .kill_i     (kill_i),
      .ilim_i     (ilim_i[ch]),
      .gate_o     (gate_o[ch]),
      .short_set_o(short_set_o[ch])
    );
    lss_open_det #(.T_OL(T_OL), .T_OLF(T_OLF)) u_open (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .gate_i    (gate_o[ch]),
      .on_chk_i  (ol_on_en_i[ch]),
      .dlow_i    (dlow_i[ch]),
      .open_set_o(open_set_o[ch])
    );
  end

  a_r8_kill_gates_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |-> gate_o == '0);
endmodule

// File: tb/lss_fault_ctrl_tb.sv
module lss_fault_ctrl_tb;
  localparam int N = 4, T_SS = 16, T_FS = 4, T_REF = 40, T_OL = 12, T_OLF = 3;

  logic clk = 1'b0, rst_ni = 1'b0, kill = 1'b0;
  logic [N-1:0] cmd = '0, olen = '0, ilim = '0, dlow = '0;
  logic [N-1:0] gate, sset, oset;
  int checks = 0, fails = 0;
  int ss0 = 0, os2 = 0;

  always #2 clk = ~clk;

  lss_fault_ctrl #(.N_CH(N), .T_SS(T_SS), .T_FS(T_FS), .T_REF(T_REF),
                   .T_OL(T_OL), .T_OLF(T_OLF)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd), .ol_on_en_i(olen),
    .ilim_i(ilim), .dlow_i(dlow), .kill_i(kill),
    .gate_o(gate), .short_set_o(sset), .open_set_o(oset));

  always @(negedge clk) begin
    if (sset[0]) ss0++;
    if (oset[2]) os2++;
  end

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset;
    step(3);
    chk("R1 gate in reset", gate, 0);
    chk("R1 sets in reset", {sset, oset}, 0);
    rst_ni = 1'b1;
    step();
    chk("R1 after release", {gate, sset, oset}, 0);
  endtask

  task automatic t_turnon_short;
    cmd[0] = 1; ilim[0] = 1;
    step(T_SS);
    chk("R2 gate held in window", gate[0], 1);
    chk("R2 no early set", sset[0], 0);
    step();
    chk("R2 gate off", gate[0], 0);
    chk("R2 short set", sset[0], 1);
    step();
    chk("R12 short pulse one cycle", sset[0], 0);
  endtask

  task automatic t_retry;
    int base;
    base = ss0;
    step(T_REF - 2);
    chk("R5 refresh off", gate[0], 0);
    step();
    chk("R5 retry on", gate[0], 1);
    step(T_SS - 1);
    chk("R5 sense still on", gate[0], 1);
    step();
    chk("R5 retry off again", gate[0], 0);
    chk("R5 no new pulse", ss0 - base, 0);
  endtask

  task automatic t_resume;
    int base;
    base = ss0;
    step(T_REF);
    chk("R6 retry on", gate[0], 1);
    ilim[0] = 0;
    step(T_SS + 5);
    chk("R6 stays on", gate[0], 1);
    chk("R6 no pulse", ss0 - base, 0);
  endtask

  task automatic t_mid_short;
    int base;
    base = ss0;
    ilim[0] = 1;
    step(T_FS - 1);
    ilim[0] = 0;
    step(10);
    chk("R4 burst ignored gate", gate[0], 1);
    chk("R4 burst ignored set", ss0 - base, 0);
    ilim[0] = 1;
    step(T_FS - 1);
    chk("R4 on before fault time", gate[0], 1);
    step();
    chk("R4 gate off", gate[0], 0);
    chk("R4 short set", sset[0], 1);
  endtask

  task automatic t_cmd_off;
    cmd[0] = 0; ilim[0] = 0;
    step();
    chk("R7 off", gate[0], 0);
    cmd[0] = 1;
    step();
    chk("R7 retry abandoned, on at once", gate[0], 1);
    cmd[0] = 0;
    step();
    chk("R7 off next cycle", gate[0], 0);
  endtask

  task automatic t_transient;
    int base;
    base = ss0;
    cmd[0] = 1; ilim[0] = 1;
    step(T_SS - 1);
    ilim[0] = 0;
    step(30);
    chk("R3 stays on", gate[0], 1);
    chk("R3 no short", ss0 - base, 0);
  endtask

  task automatic t_kill;
    cmd[1] = 1;
    step(3);
    chk("R8 on before kill", gate[1:0], 3);
    kill = 1;
    #1;
    chk("R8 same-cycle off", gate, 0);
    step(5);
    chk("R8 held off", gate, 0);
    kill = 0;
    step();
    chk("R8 back on", gate[1:0], 3);
    cmd[1:0] = 0;
    step();
  endtask

  task automatic t_open_turnoff;
    cmd[2] = 1;
    step(5);
    cmd[2] = 0; dlow[2] = 1;
    step(T_OL);
    chk("R9 not before sense time", oset[2], 0);
    step();
    chk("R9 open set", oset[2], 1);
    step();
    chk("R12 open pulse one cycle", oset[2], 0);
    step(8);
    chk("R12 no repeat", os2, 1);
    dlow[2] = 0;
    step();
  endtask

  task automatic t_open_settled;
    dlow[3] = 1;
    step(T_OLF);
    chk("R10 fast open set", oset[3], 1);
    dlow[3] = 0;
    step();
    chk("R10 pulse ends", oset[3], 0);
  endtask

  task automatic t_open_on;
    int base;
    cmd[2] = 1;
    step(5);
    base = os2;
    dlow[2] = 1;
    step(2 * T_OL);
    chk("R11 ignored when disabled", os2 - base, 0);
    dlow[2] = 0;
    olen[2] = 1;
    step(2);
    dlow[2] = 1;
    step(T_OL - 1);
    chk("R11 not early", oset[2], 0);
    step();
    chk("R11 on-state open set", oset[2], 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_turnon_short();
    t_retry();
    t_resume();
    t_mid_short();
    t_cmd_off();
    t_transient();
    t_kill();
    t_open_turnoff();
    t_open_settled();
    t_open_on();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule